// File: doc/BRIEF.md
# Line-Loss Recovery Spiral Search Sequencer

This block decides the two motor drive settings of a line-tracking vehicle on every sensor sample tick. When the line decoder reports a valid steering code, the block turns the code into a left and right wheel setting. Each setting has a speed level (stopped, half or near-full duty) and a direction. The block keeps that setting as the last good action. When the line disappears, the block keeps repeating the last good action so that short dropouts and overshoot in sharp bends are ridden through.

If the line stays lost for a configurable number of ticks (5 s at a 2.1 ms tick), the block switches to a search pattern. The vehicle circles to the right with the outer wheel at full speed. The inner wheel speed steps up once per second (every 476 ticks), so the circle widens into a spiral. When the inner wheel matches the outer wheel the path is straight. After one interval in that state, the search starts again from the tightest circle. Any detected line ends the search at once.

A separate no-surface flag stops both motors in the same cycle, without waiting for a tick. While that flag is set, the sequencer state is frozen. Code 7 from the decoder is a reset request. It returns the block to its idle follow state with a stopped drive and cleared counters. Duty-cycle generation and sensor decoding sit outside this block.

Top module: `spiral_search_seq`

## Requirements
- R1: After reset both speed outputs are 0 (stopped) and both direction outputs are 1 (forward). Speed encoding is 0 = stopped, 1 = half duty, 2 = near-full duty. Direction encoding is 1 = forward, 0 = reverse.
- R2: On a tick with `line_lost`=0 and `no_surface`=0, the code on `cmd` sets the drive, written as (left speed/dir, right speed/dir). 0 gives (1/rev, 2/fwd); 1 gives (2/fwd, 1/rev); 2 gives (0/fwd, 2/fwd); 3 gives (2/fwd, 0/fwd); 4 gives (1/fwd, 2/fwd); 5 gives (2/fwd, 1/fwd); 6 gives (2/fwd, 2/fwd).
- R3: On the first LOST_TICKS-1 consecutive ticks with `line_lost`=1, the outputs keep the drive of the last line-present tick.
- R4: On the LOST_TICKS-th consecutive lost tick, the block enters search. The left wheel goes to speed 2 forward and the right (inner) wheel to speed 0 forward.
- R5: In search, the inner wheel speed steps 0 -> 1 -> 2 on every SEC_TICKS-th lost tick, while the outer wheel stays at speed 2 forward.
- R6: When the inner wheel has been at speed 2 (straight) for one full interval, the next step returns it to speed 0 and the spiral restarts.
- R7: A tick with `line_lost`=0 ends hold or search. The outputs take the new code's drive on that tick, and the lost-tick count restarts from zero.
- R8: `no_surface`=1 forces both speeds to 0 in the same cycle. Ticks while it is set change no state. When it clears, the earlier drive and lost-tick count are in effect again.
- R9: Code 7 on a line-present tick sets the stopped drive (R1 values) and clears the counters. A later loss holds that stopped drive for LOST_TICKS-1 ticks before search starts.
- R10: Cycles without `tick` change neither the outputs nor the state, whatever `cmd` and `line_lost` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle sample enable (2.1 ms period in use) |
| cmd | input | 3 | Decoded steering code, 0..6 actions, 7 reset request |
| line_lost | input | 1 | No sensor sees the line |
| no_surface | input | 1 | Vehicle sees no surface; stop at once |
| l_speed | output | 2 | Left wheel speed level |
| l_fwd | output | 1 | Left wheel direction, 1 = forward |
| r_speed | output | 2 | Right wheel speed level |
| r_fwd | output | 1 | Right wheel direction, 1 = forward |

## Verification
A lost-tick count that is off by one shows up on the tick where the right wheel should drop to stopped and the left should go to full. The bench samples right after each tick, so the error appears within that tick. A wrong inner-step index or a missed wrap shows as a wrong right-wheel speed at the first interval boundary after the fault. A state that moves during a no-surface stretch only appears once the flag clears: the bench then counts the remaining lost ticks to search entry and compares the drive.

// File: rtl/spiral_pkg.sv
package spiral_pkg;

    localparam logic [1:0] SPD_OFF  = 2'd0;
    localparam logic [1:0] SPD_HALF = 2'd1;
    localparam logic [1:0] SPD_FULL = 2'd2;

    typedef struct packed {
        logic [1:0] l_spd;
        logic       l_fwd;
        logic [1:0] r_spd;
        logic       r_fwd;
    } drive_t;

    typedef enum logic [1:0] {
        ST_FOLLOW = 2'd0,
        ST_HOLD   = 2'd1,
        ST_SEARCH = 2'd2
    } mode_e;

    localparam drive_t DRV_STOP = '{l_spd: SPD_OFF, l_fwd: 1'b1, r_spd: SPD_OFF, r_fwd: 1'b1};

endpackage

// File: rtl/ssq_action_map.sv
module ssq_action_map
    import spiral_pkg::*;
(
    input  logic [2:0] code,
    output drive_t     drv
);
    always_comb begin
        drv = DRV_STOP;
        unique case (code)
            3'd0: drv = '{l_spd: SPD_HALF, l_fwd: 1'b0, r_spd: SPD_FULL, r_fwd: 1'b1};
            3'd1: drv = '{l_spd: SPD_FULL, l_fwd: 1'b1, r_spd: SPD_HALF, r_fwd: 1'b0};
            3'd2: drv = '{l_spd: SPD_OFF,  l_fwd: 1'b1, r_spd: SPD_FULL, r_fwd: 1'b1};
            3'd3: drv = '{l_spd: SPD_FULL, l_fwd: 1'b1, r_spd: SPD_OFF,  r_fwd: 1'b1};
            3'd4: drv = '{l_spd: SPD_HALF, l_fwd: 1'b1, r_spd: SPD_FULL, r_fwd: 1'b1};
            3'd5: drv = '{l_spd: SPD_FULL, l_fwd: 1'b1, r_spd: SPD_HALF, r_fwd: 1'b1};
            3'd6: drv = '{l_spd: SPD_FULL, l_fwd: 1'b1, r_spd: SPD_FULL, r_fwd: 1'b1};
            default: drv = DRV_STOP;
        endcase
    end
endmodule

// File: rtl/ssq_spiral_drive.sv
module ssq_spiral_drive
    import spiral_pkg::*;
#(
    parameter bit INNER_RIGHT = 1'b1
) (
    input  logic [1:0] step,
    output drive_t     drv
);
    generate
        if (INNER_RIGHT) begin : g_right_turn
            assign drv = '{l_spd: SPD_FULL, l_fwd: 1'b1, r_spd: step, r_fwd: 1'b1};
        end else begin : g_left_turn
            assign drv = '{l_spd: step, l_fwd: 1'b1, r_spd: SPD_FULL, r_fwd: 1'b1};
        end
    endgenerate
endmodule

// File: rtl/spiral_search_seq.sv
module spiral_search_seq
    import spiral_pkg::*;
#(
    parameter int LOST_TICKS = 2381,
    parameter int SEC_TICKS  = 476
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] cmd,
    input  logic       line_lost,
    input  logic       no_surface,
    output logic [1:0] l_speed,
    output logic       l_fwd,
    output logic [1:0] r_speed,
    output logic       r_fwd
);
    localparam int MAX_WIN = (LOST_TICKS > SEC_TICKS) ? LOST_TICKS : SEC_TICKS;
    localparam int CNT_W   = $clog2(MAX_WIN + 1);
    localparam logic [CNT_W-1:0] LOST_LAST = CNT_W'(LOST_TICKS - 1);
    localparam logic [CNT_W-1:0] SEC_LAST  = CNT_W'(SEC_TICKS - 1);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       step;
        drive_t           hold;
    } seq_t;

    seq_t   seq_q, seq_d;
    drive_t map_drv, spiral_drv, out_drv;
    logic   sample_en;

    ssq_action_map u_map (
        .code (cmd),
        .drv  (map_drv)
    );

    ssq_spiral_drive #(.INNER_RIGHT(1'b1)) u_spiral (
        .step (seq_q.step),
        .drv  (spiral_drv)
    );

    assign sample_en = tick && !no_surface;

    always_comb begin
        seq_d = seq_q;
        if (sample_en) begin
            if (!line_lost) begin
                // line present: follow the code; code 7 maps to the stopped drive
                seq_d.mode = ST_FOLLOW;
                seq_d.cnt  = '0;
                seq_d.step = SPD_OFF;
                seq_d.hold = map_drv;
            end else if (seq_q.mode == ST_SEARCH) begin
                if (seq_q.cnt == SEC_LAST) begin
                    seq_d.cnt  = '0;
                    seq_d.step = (seq_q.step == SPD_FULL) ? SPD_OFF : seq_q.step + 2'd1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end else begin
                if (seq_q.cnt == LOST_LAST) begin
                    seq_d.mode = ST_SEARCH;
                    seq_d.cnt  = '0;
                    seq_d.step = SPD_OFF;
                end else begin
                    seq_d.mode = ST_HOLD;
                    seq_d.cnt  = seq_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{mode: ST_FOLLOW, cnt: '0, step: SPD_OFF, hold: DRV_STOP};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        out_drv = (seq_q.mode == ST_SEARCH) ? spiral_drv : seq_q.hold;
        if (no_surface) begin
            out_drv = DRV_STOP;
        end
    end

    assign l_speed = out_drv.l_spd;
    assign l_fwd   = out_drv.l_fwd;
    assign r_speed = out_drv.r_spd;
    assign r_fwd   = out_drv.r_fwd;

    // R10: nothing moves between ticks
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(seq_q));

    // R8: ticks during no-surface leave the state frozen
    assert_nosurf_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && no_surface) |=> $stable(seq_q));

    // R7: a line-present tick returns to follow with a cleared count
    assert_line_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !line_lost) |=> (seq_q.mode == ST_FOLLOW && seq_q.cnt == '0));

    // R4: search always starts at the tightest circle
    assert_search_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.mode == ST_SEARCH) |-> (seq_q.step == SPD_OFF && seq_q.cnt == '0));

    // R3: hold count never reaches the loss window
    assert_hold_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode != ST_SEARCH) |-> (seq_q.cnt <= LOST_LAST));

    // R5: interval count stays inside one second in search
    assert_sec_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode == ST_SEARCH) |-> (seq_q.cnt <= SEC_LAST));

    // R6: inner step wraps after the straight level
    assert_step_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && line_lost && seq_q.mode == ST_SEARCH && seq_q.cnt == SEC_LAST
         && seq_q.step == SPD_FULL) |=> (seq_q.step == SPD_OFF));

    // R9: reset request leaves a stopped drive
    assert_reset_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !line_lost && cmd == 3'd7) |=> (seq_q.hold == DRV_STOP));

endmodule

// File: tb/spiral_search_seq_tb_top.sv
module spiral_search_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOST = 6;
    localparam int SEC  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       line_lost = 1'b0;
    logic       no_surface = 1'b0;
    logic [1:0] l_speed, r_speed;
    logic       l_fwd, r_fwd;

    int errors = 0;
    int checks = 0;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spiral_search_seq #(.LOST_TICKS(LOST), .SEC_TICKS(SEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd),
        .line_lost(line_lost), .no_surface(no_surface),
        .l_speed(l_speed), .l_fwd(l_fwd), .r_speed(r_speed), .r_fwd(r_fwd)
    );

    function automatic logic [5:0] dv(input int ls, input bit lf, input int rs, input bit rf);
        return {2'(ls), lf, 2'(rs), rf};
    endfunction

    function automatic logic [5:0] code_drive(input int c);
        case (c)
            0: return dv(1, 0, 2, 1);
            1: return dv(2, 1, 1, 0);
            2: return dv(0, 1, 2, 1);
            3: return dv(2, 1, 0, 1);
            4: return dv(1, 1, 2, 1);
            5: return dv(2, 1, 1, 1);
            6: return dv(2, 1, 2, 1);
            default: return dv(0, 1, 0, 1);
        endcase
    endfunction

    function automatic logic [5:0] spiral_at(input int n);
        return dv(2, 1, ((n - LOST) / SEC) % 3, 1);
    endfunction

    task automatic compare(input logic [5:0] e, input string tag);
        logic [5:0] act;
        act = {l_speed, l_fwd, r_speed, r_fwd};
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, e);
        end
    endtask

    // driver: one tick, expected result queued for the monitor
    task automatic apply(input int c, input bit lost, input bit ns, input logic [5:0] e, input string tag);
        @(negedge clk);
        cmd = 3'(c); line_lost = lost; no_surface = ns; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic check_now(input logic [5:0] e, input string tag);
        wait (exp_q.size() == 0);
        @(negedge clk);
        #2;
        compare(e, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_now(dv(0, 1, 0, 1), "R1 reset drive");

        for (int c = 0; c <= 6; c++) apply(c, 0, 0, code_drive(c), $sformatf("R2 code %0d", c));

        // R10: input changes without tick
        @(negedge clk); cmd = 3'd0; line_lost = 1'b1;
        repeat (4) @(negedge clk);
        check_now(code_drive(6), "R10 no tick keeps drive");
        line_lost = 1'b0;

        // R3..R6: hold then spiral
        apply(3, 0, 0, code_drive(3), "R2 code 3 before loss");
        for (int n = 1; n <= 20; n++) begin
            if (n < LOST) apply(0, 1, 0, code_drive(3), $sformatf("R3 hold tick %0d", n));
            else if (n < LOST + 3 * SEC) apply(0, 1, 0, spiral_at(n), $sformatf("R4 R5 search tick %0d", n));
            else apply(0, 1, 0, spiral_at(n), $sformatf("R6 wrap tick %0d", n));
        end

        // R7: line back during search
        apply(4, 0, 0, code_drive(4), "R7 line ends search");

        // R8: no surface
        @(negedge clk); no_surface = 1'b1;
        #2; compare(dv(0, 1, 0, 1), "R8 immediate stop");
        for (int k = 0; k < 8; k++) apply(1, 1, 1, dv(0, 1, 0, 1), "R8 stopped while flagged");
        @(negedge clk); no_surface = 1'b0;
        check_now(code_drive(4), "R8 drive restored");
        for (int n = 1; n <= LOST; n++) begin
            if (n < LOST) apply(2, 1, 0, code_drive(4), $sformatf("R8 R3 count frozen tick %0d", n));
            else apply(2, 1, 0, spiral_at(n), "R8 R4 search after freeze");
        end
        apply(0, 1, 0, spiral_at(LOST + 1), "R5 search continues");

        // R9: reset request
        apply(7, 0, 0, dv(0, 1, 0, 1), "R9 reset request stops");
        for (int n = 1; n <= LOST; n++) begin
            if (n < LOST) apply(5, 1, 0, dv(0, 1, 0, 1), $sformatf("R9 hold stop tick %0d", n));
            else apply(5, 1, 0, spiral_at(n), "R9 R4 full window after reset request");
        end

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule